// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block takes configuration bytes from a processor over a parallel write port and gives a core clock domain two multi-byte control words, a center frequency and an offset frequency. Each accepted byte lands in a staging bank. The words the core sees come from a separate active bank, and that bank changes only on a commit request. Because of this, a word that spans several bytes moves from its old value to its new value in one step. Software never exposes a half-written word to the datapath.

The write port is clocked by its own strobe, which has no fixed relation to the core clock. The commit request (`update_ni`) and the control-reset request (`creset_ni`) are both active low and asynchronous. Each passes through a two-flop synchronizer into the core domain.

- A commit copies the whole staging bank once, on the first core edge after the synchronized request is seen.
- The active bank then holds for as long as the request stays asserted.
- A control reset clears the active bank to zero. It does so only while the commit request is also asserted, and it overrides the copy.
- The primary reset `rst_ni` clears both banks asynchronously.

Top module: `cfgreg_dbuf`

## Requirements
- R1: On a rising edge of `wr_clk_i` with `wr_en_ni` low, `data_i` is stored in staging register `addr_i`. Registers 0 to 3 form `center_o` and registers 4 to 7 form `offset_o`, with the lowest address as the least significant byte.
- R2: A rising edge of `wr_clk_i` while `wr_en_ni` is high changes no staging register.
- R3: Writes to addresses 8 to 15 change no staging register.
- R4: Staging writes alone never change `center_o` or `offset_o`.
- R5: When `update_ni` falls, the full staging bank appears on the outputs after the third rising edge of `clk_i` and not after the second.
- R6: Each assertion of `update_ni` copies the bank once. The outputs stay stable while it remains low, even if staging writes occur.
- R7: When `creset_ni` and `update_ni` are both low, the outputs become zero three core edges after both are low. This takes priority over a pending copy.
- R8: `creset_ni` low while `update_ni` is high has no effect on the outputs.
- R9: A control reset leaves the staging bank unchanged, so a later commit restores the staged words.
- R10: `rst_ni` low asynchronously forces both outputs and all staging registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Primary asynchronous reset, active low |
| wr_clk_i | input | 1 | Write strobe; data is captured on its rising edge |
| wr_en_ni | input | 1 | Write enable, active low |
| addr_i | input | 4 | Staging register select |
| data_i | input | 8 | Write data byte |
| update_ni | input | 1 | Commit request, active low, asynchronous |
| creset_ni | input | 1 | Control-reset request, active low, only acts while `update_ni` is low |
| center_o | output | 32 | Active center frequency word |
| offset_o | output | 32 | Active offset frequency word |

## Verification
The assertions check four things on every core cycle:
- The outputs hold whenever the delayed commit request is idle.
- A commit loads exactly the staged contents.
- A combined reset-and-commit request yields zero.
- The primary reset forces zero outputs.

Address decoding, the ignored-enable and out-of-range write cases, and the byte order within each word are only visible through the bench's scenarios. The same applies to the exact three-edge latency boundary and to the retention of staging across a control reset. The bench covers these by sweeping every address with the enable both asserted and deasserted, and by committing after each write.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2
  } commit_act_e;
endpackage

// File: rtl/cfgreg_sync.sv
module cfgreg_sync #(
  parameter int        WIDTH   = 2,
  parameter logic      RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cfgreg_stage.sv
module cfgreg_stage #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int N_REGS = 8,
  localparam int STAGE_W = DATA_W * N_REGS
) (
  input  logic               wr_clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [STAGE_W-1:0] stage_o
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] byte_q;

    assign hit = !wr_en_ni && (addr_i == ADDR_W'(g));

    always_ff @(posedge wr_clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= '0;
      else if (hit) byte_q <= data_i;
    end

    assign stage_o[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/cfgreg_commit.sv
module cfgreg_commit
  import cfgreg_pkg::*;
#(
  parameter int STAGE_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               crst_i,
  input  logic [STAGE_W-1:0] stage_i,
  output logic [STAGE_W-1:0] active_o
);
  logic               upd_q;
  logic [STAGE_W-1:0] active_q;
  commit_act_e        act;

  // reset beats copy; copy only on first cycle of request
  always_comb begin
    if (crst_i && upd_i)      act = ACT_CLEAR;
    else if (upd_i && !upd_q) act = ACT_LOAD;
    else                      act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q    <= 1'b0;
      active_q <= '0;
    end else begin
      upd_q <= upd_i;
      unique case (act)
        ACT_CLEAR: active_q <= '0;
        ACT_LOAD:  active_q <= stage_i;
        default:   active_q <= active_q;
      endcase
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/cfgreg_dbuf.sv
module cfgreg_dbuf #(
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 4,
  parameter int BYTES_PER_WORD = 4,
  localparam int N_WORDS = 2,
  localparam int N_REGS  = N_WORDS * BYTES_PER_WORD,
  localparam int WORD_W  = DATA_W * BYTES_PER_WORD,
  localparam int STAGE_W = WORD_W * N_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_clk_i,
  input  logic              wr_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              update_ni,
  input  logic              creset_ni,
  output logic [WORD_W-1:0] center_o,
  output logic [WORD_W-1:0] offset_o
);
  logic [STAGE_W-1:0] stage_w;
  logic [STAGE_W-1:0] active_w;
  logic [1:0]         req_n_s;

  cfgreg_stage #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_REGS (N_REGS)
  ) u_stage (
    .wr_clk_i (wr_clk_i),
    .rst_ni   (rst_ni),
    .wr_en_ni (wr_en_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .stage_o  (stage_w)
  );

  cfgreg_sync #(
    .WIDTH   (2),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({creset_ni, update_ni}),
    .sync_o  (req_n_s)
  );

  cfgreg_commit #(
    .STAGE_W (STAGE_W)
  ) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (~req_n_s[0]),
    .crst_i   (~req_n_s[1]),
    .stage_i  (stage_w),
    .active_o (active_w)
  );

  assign center_o = active_w[0 +: WORD_W];
  assign offset_o = active_w[WORD_W +: WORD_W];
endmodule

// File: rtl/cfgreg_dbuf_chk.sv
module cfgreg_dbuf_chk #(
  parameter int DATA_W         = 8,
  parameter int BYTES_PER_WORD = 4,
  localparam int WORD_W  = DATA_W * BYTES_PER_WORD,
  localparam int STAGE_W = 2 * WORD_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               update_ni,
  input logic               creset_ni,
  input logic [WORD_W-1:0]  center_o,
  input logic [WORD_W-1:0]  offset_o,
  input logic [STAGE_W-1:0] stage_i
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  // R6 / R8: no change unless the delayed request is active
  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(update_ni, 2)) |=> ($stable(center_o) && $stable(offset_o)));

  // R5: a fresh request without reset loads the staged bank
  assert_commit_loads_stage_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(update_ni, 3) && !$past(update_ni, 2) && $past(creset_ni, 2))
    |=> ({offset_o, center_o} == $past(stage_i)));

  // R7: combined request clears
  assert_ctl_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(update_ni, 2) && !$past(creset_ni, 2))
    |=> (center_o == '0 && offset_o == '0));

  // R10
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_zero_R10: assert (center_o == '0 && offset_o == '0);
    end
  end
endmodule

bind cfgreg_dbuf cfgreg_dbuf_chk #(
  .DATA_W         (DATA_W),
  .BYTES_PER_WORD (BYTES_PER_WORD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .update_ni (update_ni),
  .creset_ni (creset_ni),
  .center_o  (center_o),
  .offset_o  (offset_o),
  .stage_i   (stage_w)
);

// File: tb/tb_cfgreg_dbuf.sv
`timescale 1ns/1ps
module tb_cfgreg_dbuf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_clk_i = 1'b0;
  logic        wr_en_ni = 1'b1;
  logic [3:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        update_ni = 1'b1;
  logic        creset_ni = 1'b1;
  logic [31:0] center_o;
  logic [31:0] offset_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mdl [8];
  logic [31:0] exp_c = '0;
  logic [31:0] exp_o = '0;

  cfgreg_dbuf dut (
    .clk_i, .rst_ni, .wr_clk_i, .wr_en_ni, .addr_i, .data_i,
    .update_ni, .creset_ni, .center_o, .offset_o
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act_c, input logic [31:0] act_o,
                     input logic [31:0] e_c, input logic [31:0] e_o);
    checks++;
    if (act_c !== e_c || act_o !== e_o) begin
      errors++;
      $display("FAIL %s: center=%h offset=%h expected center=%h offset=%h",
               req, act_c, act_o, e_c, e_o);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic en_n);
    #1 addr_i = a; data_i = d; wr_en_ni = en_n;
    #2 wr_clk_i = 1'b1;
    #2 wr_clk_i = 1'b0;
    #1 wr_en_ni = 1'b1;
    if (!en_n && a < 4'd8) mdl[a[2:0]] = d;  // R1/R2/R3 model
  endtask

  function automatic logic [31:0] word_of(input int base);
    return {mdl[base+3], mdl[base+2], mdl[base+1], mdl[base]};
  endfunction

  // R5: old value after two edges, staged value after the third
  task automatic commit(input string req);
    @(negedge clk_i) update_ni = 1'b0;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i) chk("R5 latency hold", center_o, offset_o, exp_c, exp_o);
    @(posedge clk_i);
    @(negedge clk_i);
    exp_c = word_of(0);
    exp_o = word_of(4);
    chk(req, center_o, offset_o, exp_c, exp_o);
    update_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: center=%h offset=%h expected completion", center_o, offset_o);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset state", center_o, offset_o, 32'h0, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 byte order, R4 no effect before commit
    for (int a = 0; a < 8; a++) wr(4'(a), 8'(8'h11 * (a + 1)), 1'b0);
    repeat (4) @(negedge clk_i);
    chk("R4 staged only", center_o, offset_o, 32'h0, 32'h0);
    commit("R1 byte order");
    chk("R1 center value", center_o, offset_o, 32'h44332211, 32'h88776655);

    // R1/R2/R3 sweep of every address, enable both ways
    for (int a = 0; a < 16; a++) begin
      for (int en = 0; en < 2; en++) begin
        wr(4'(a), 8'(a * 37 + en * 91 + 5), 1'(en));
        @(negedge clk_i);
        chk(en ? "R2 enable high ignored" : (a < 8 ? "R4 staged only" : "R3 address ignored"),
            center_o, offset_o, exp_c, exp_o);
        commit(en ? "R2 enable high ignored" : (a < 8 ? "R1 sweep" : "R3 address ignored"));
      end
    end

    // R6: single copy while held low, writes during hold invisible
    wr(4'd0, 8'hA5, 1'b0);
    wr(4'd7, 8'h5A, 1'b0);
    @(negedge clk_i) update_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    exp_c = word_of(0); exp_o = word_of(4);
    chk("R6 first copy", center_o, offset_o, exp_c, exp_o);
    wr(4'd1, 8'hC3, 1'b0);
    wr(4'd5, 8'h3C, 1'b0);
    repeat (6) @(negedge clk_i);
    chk("R6 held stable", center_o, offset_o, exp_c, exp_o);
    update_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R6 release no copy", center_o, offset_o, exp_c, exp_o);
    commit("R6 next commit");

    // R8: control reset without update
    @(negedge clk_i) creset_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R8 ctl reset ignored", center_o, offset_o, exp_c, exp_o);
    // R7: both low, reset wins over pending copy
    wr(4'd2, 8'h99, 1'b0);
    @(negedge clk_i) update_ni = 1'b0;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i) chk("R7 before clear", center_o, offset_o, exp_c, exp_o);
    @(posedge clk_i);
    @(negedge clk_i);
    exp_c = '0; exp_o = '0;
    chk("R7 cleared", center_o, offset_o, exp_c, exp_o);
    creset_ni = 1'b1; update_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R7 stays clear", center_o, offset_o, exp_c, exp_o);
    // R9: staging retained
    commit("R9 staging kept");

    // R10: primary reset clears both banks
    @(negedge clk_i) #2 rst_ni = 1'b0;
    #1 chk("R10 async clear", center_o, offset_o, 32'h0, 32'h0);
    exp_c = '0; exp_o = '0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (2) @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    commit("R10 staging cleared");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule